// File: doc/BRIEF.md
# Debug Exception Entry Arbiter

This block sits beside one pipeline stage of a processor and decides, for the instruction held in that stage, whether a debug exception is taken. Five trigger sources can ask for entry. Two are break instructions, in a wide and a narrow encoding. The others are an instruction-address breakpoint hit, an instruction-count expiry and a data breakpoint hit that names the comparator that matched. A request is honoured only while the current interrupt level is below the fixed debug level of 6.

When the exception is taken, the block reports one winning source in the cause register. It stores the address of the triggering instruction in the debug exception PC register and writes the low five status bits: the exception-mode flag goes to 1 and the interrupt level goes to 6. In that same cycle it raises a one-cycle redirect to the debug vector. The front end uses the redirect to fetch the handler, and the status logic uses the write strobe to merge the new low bits.

Top module: `dbg_entry_arbiter`

## Requirements
- R1: While reset is held, and in the first cycles after its release, `cause_o`, `epc_o`, `ps_low_o`, `ps_low_we_o` and `redirect_o` are all zero.
- R2: No entry happens when `cur_level` is 6 or higher, whatever triggers are raised. The redirect stays low, and the cause and PC registers keep their values.
- R3: A single source gives these cause values: instruction count 0x001 (bit 0), instruction breakpoint 0x002 (bit 1), data breakpoint 0x004 (bit 2), wide break 0x008 (bit 3), narrow break 0x010 (bit 4). Exactly one of bits 4..0 is set after each entry.
- R4: For a data breakpoint, the comparator index is placed in the cause register from bit 8 upward. Index 1 gives 0x104 and index 3 gives 0x304.
- R5: Instruction count has the highest priority. With all five sources raised, the cause is 0x001.
- R6: An instruction breakpoint wins over a break instruction on the same instruction, and the cause is 0x002.
- R7: Break instructions win over a data breakpoint, and a wide break wins over a narrow one. Wide plus data breakpoint gives 0x008. Narrow plus data breakpoint gives 0x010.
- R8: On entry, `epc_o` takes the `req_pc` of the triggering instruction itself.
- R9: On entry, `ps_low_we_o` pulses and `ps_low_o` becomes 0x16: bit 4 is exception mode, and bits 3..0 hold level 6.
- R10: `redirect_o` is high for exactly the one cycle in which the registers show the new entry. `redirect_pc_o` always equals the `VECTOR` parameter.
- R11: When `req_valid` is low, or no trigger is raised, no entry happens and the cause and PC registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Stage holds a real instruction |
| req_pc | input | PC_W | Address of that instruction |
| cur_level | input | LVL_W | Current interrupt level |
| trg_icount | input | 1 | Instruction count expired |
| trg_ibreak | input | 1 | Instruction-address breakpoint hit |
| trg_brk_wide | input | 1 | Wide break instruction |
| trg_brk_narrow | input | 1 | Narrow break instruction |
| trg_dbreak | input | 1 | Data breakpoint hit |
| trg_dbreak_idx | input | IDX_W | Index of the matching data comparator |
| cause_o | output | 8+IDX_W | Debug cause register |
| epc_o | output | PC_W | Debug exception PC register |
| ps_low_o | output | 5 | New low status bits |
| ps_low_we_o | output | 1 | Write strobe for the low status bits |
| redirect_o | output | 1 | One-cycle redirect to the debug vector |
| redirect_pc_o | output | PC_W | Debug vector address |

## Verification
Every result is registered once. A request presented before a clock edge shows up on the cause, PC, status-write and redirect outputs just after that same edge, and it is gone again after the following edge. The driver applies each stimulus at a falling edge and pushes the expected outcome into a queue. The monitor pops one item one nanosecond after each rising edge, so every comparison falls in the single cycle where that result is due. Non-entry items check that the cause and PC registers still hold the last expected values.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
  localparam int DBG_LEVEL    = 6;
  localparam int CB_ICOUNT    = 0;
  localparam int CB_IBREAK    = 1;
  localparam int CB_DBREAK    = 2;
  localparam int CB_BRK_WIDE  = 3;
  localparam int CB_BRK_NARROW = 4;
  localparam int CB_IDX_LSB   = 8;
  localparam int PS_LOW_W     = 5;
  localparam int PS_EXCM_BIT  = 4;
endpackage

// File: rtl/dbg_level_gate.sv
module dbg_level_gate #(
  parameter int LVL_W = 4,
  parameter int LEVEL = 6
) (
  input  logic             valid_i,
  input  logic             any_trig_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             accept_o
);
  localparam logic [LVL_W-1:0] LEVEL_V = LVL_W'(LEVEL);

  always_comb begin
    accept_o = valid_i && any_trig_i && (level_i < LEVEL_V);
  end
endmodule

// File: rtl/dbg_cause_sel.sv
module dbg_cause_sel
  import dbg_entry_pkg::*;
#(
  parameter int IDX_W   = 2,
  parameter int CAUSE_W = CB_IDX_LSB + IDX_W
) (
  input  logic               icount_i,
  input  logic               ibreak_i,
  input  logic               brk_wide_i,
  input  logic               brk_narrow_i,
  input  logic               dbreak_i,
  input  logic [IDX_W-1:0]   dbreak_idx_i,
  output logic               any_o,
  output logic [CAUSE_W-1:0] cause_o
);
  always_comb begin
    cause_o = '0;
    any_o   = icount_i | ibreak_i | brk_wide_i | brk_narrow_i | dbreak_i;
    if (icount_i) begin
      cause_o[CB_ICOUNT] = 1'b1;
    end else if (ibreak_i) begin
      cause_o[CB_IBREAK] = 1'b1;
    end else if (brk_wide_i) begin
      cause_o[CB_BRK_WIDE] = 1'b1;
    end else if (brk_narrow_i) begin
      cause_o[CB_BRK_NARROW] = 1'b1;
    end else if (dbreak_i) begin
      cause_o[CB_DBREAK] = 1'b1;
      cause_o[CB_IDX_LSB +: IDX_W] = dbreak_idx_i;
    end
  end
endmodule

// File: rtl/dbg_entry_arbiter.sv
module dbg_entry_arbiter
  import dbg_entry_pkg::*;
#(
  parameter int              PC_W   = 32,
  parameter int              IDX_W  = 2,
  parameter int              LVL_W  = 4,
  parameter logic [PC_W-1:0] VECTOR = 32'h0000_0280
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [PC_W-1:0]            req_pc,
  input  logic [LVL_W-1:0]           cur_level,
  input  logic                       trg_icount,
  input  logic                       trg_ibreak,
  input  logic                       trg_brk_wide,
  input  logic                       trg_brk_narrow,
  input  logic                       trg_dbreak,
  input  logic [IDX_W-1:0]           trg_dbreak_idx,
  output logic [CB_IDX_LSB+IDX_W-1:0] cause_o,
  output logic [PC_W-1:0]            epc_o,
  output logic [PS_LOW_W-1:0]        ps_low_o,
  output logic                       ps_low_we_o,
  output logic                       redirect_o,
  output logic [PC_W-1:0]            redirect_pc_o
);
  localparam int CAUSE_W = CB_IDX_LSB + IDX_W;
  localparam logic [PS_LOW_W-1:0] PS_ENTRY =
    PS_LOW_W'((1 << PS_EXCM_BIT) | DBG_LEVEL);

  logic               rst_s0, rst_sync_n;
  logic               any_trig, accept;
  logic [CAUSE_W-1:0] cause_sel;
  logic [CAUSE_W-1:0] cause_d;
  logic [PC_W-1:0]    epc_d;
  logic [PS_LOW_W-1:0] ps_low_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s0     <= 1'b1;
      rst_sync_n <= rst_s0;
    end
  end

  dbg_cause_sel #(.IDX_W(IDX_W), .CAUSE_W(CAUSE_W)) u_sel (
    .icount_i     (trg_icount),
    .ibreak_i     (trg_ibreak),
    .brk_wide_i   (trg_brk_wide),
    .brk_narrow_i (trg_brk_narrow),
    .dbreak_i     (trg_dbreak),
    .dbreak_idx_i (trg_dbreak_idx),
    .any_o        (any_trig),
    .cause_o      (cause_sel)
  );

  dbg_level_gate #(.LVL_W(LVL_W), .LEVEL(DBG_LEVEL)) u_gate (
    .valid_i    (req_valid),
    .any_trig_i (any_trig),
    .level_i    (cur_level),
    .accept_o   (accept)
  );

  always_comb begin
    cause_d  = cause_o;
    epc_d    = epc_o;
    ps_low_d = ps_low_o;
    if (accept) begin
      cause_d  = cause_sel;
      epc_d    = req_pc;
      ps_low_d = PS_ENTRY;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cause_o     <= '0;
      epc_o       <= '0;
      ps_low_o    <= '0;
      ps_low_we_o <= 1'b0;
      redirect_o  <= 1'b0;
    end else begin
      cause_o     <= cause_d;
      epc_o       <= epc_d;
      ps_low_o    <= ps_low_d;
      ps_low_we_o <= accept;
      redirect_o  <= accept;
    end
  end

  assign redirect_pc_o = VECTOR;
endmodule

// File: rtl/dbg_entry_arbiter_chk.sv
module dbg_entry_arbiter_chk
  import dbg_entry_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 2,
  parameter int LVL_W = 4
) (
  input logic                        clk,
  input logic                        rst_sync_n,
  input logic                        req_valid,
  input logic [PC_W-1:0]             req_pc,
  input logic [LVL_W-1:0]            cur_level,
  input logic                        trg_icount,
  input logic [CB_IDX_LSB+IDX_W-1:0] cause_o,
  input logic [PC_W-1:0]             epc_o,
  input logic [PS_LOW_W-1:0]         ps_low_o,
  input logic                        ps_low_we_o,
  input logic                        redirect_o
);
  localparam logic [LVL_W-1:0] LV = LVL_W'(DBG_LEVEL);

  assert_level_mask_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && cur_level >= LV) |=> !redirect_o);

  assert_onehot_cause_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    redirect_o |-> $onehot(cause_o[4:0]));

  assert_icount_first_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && trg_icount && cur_level < LV) |=>
      (redirect_o && cause_o == (CB_IDX_LSB+IDX_W)'(1)));

  assert_epc_own_pc_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    redirect_o |-> (epc_o == $past(req_pc)));

  assert_status_write_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    redirect_o |-> (ps_low_we_o && ps_low_o == 5'h16));

  assert_hold_regs_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !redirect_o |-> ($stable(cause_o) && $stable(epc_o)));
endmodule

bind dbg_entry_arbiter dbg_entry_arbiter_chk #(
  .PC_W(PC_W), .IDX_W(IDX_W), .LVL_W(LVL_W)
) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .req_valid   (req_valid),
  .req_pc      (req_pc),
  .cur_level   (cur_level),
  .trg_icount  (trg_icount),
  .cause_o     (cause_o),
  .epc_o       (epc_o),
  .ps_low_o    (ps_low_o),
  .ps_low_we_o (ps_low_we_o),
  .redirect_o  (redirect_o)
);

// File: tb/dbg_entry_arbiter_tb.sv
`timescale 1ns/1ps
module dbg_entry_arbiter_tb;
  localparam int PC_W = 32;
  localparam int IDX_W = 2;
  localparam int CW = 8 + IDX_W;
  localparam logic [PC_W-1:0] VEC = 32'h0000_0280;

  typedef struct {
    logic            taken;
    logic [CW-1:0]   cause;
    logic [PC_W-1:0] epc;
    string           tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, trg_icount, trg_ibreak, trg_brk_wide, trg_brk_narrow, trg_dbreak;
  logic [PC_W-1:0] req_pc;
  logic [3:0] cur_level;
  logic [IDX_W-1:0] trg_dbreak_idx;
  logic [CW-1:0] cause_o;
  logic [PC_W-1:0] epc_o, redirect_pc_o;
  logic [4:0] ps_low_o;
  logic ps_low_we_o, redirect_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  exp_t q[$];
  logic [CW-1:0]   hold_cause = '0;
  logic [PC_W-1:0] hold_epc = '0;

  always #2.5 clk = ~clk;

  dbg_entry_arbiter #(.PC_W(PC_W), .IDX_W(IDX_W), .LVL_W(4), .VECTOR(VEC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc),
    .cur_level(cur_level), .trg_icount(trg_icount), .trg_ibreak(trg_ibreak),
    .trg_brk_wide(trg_brk_wide), .trg_brk_narrow(trg_brk_narrow),
    .trg_dbreak(trg_dbreak), .trg_dbreak_idx(trg_dbreak_idx),
    .cause_o(cause_o), .epc_o(epc_o), .ps_low_o(ps_low_o),
    .ps_low_we_o(ps_low_we_o), .redirect_o(redirect_o),
    .redirect_pc_o(redirect_pc_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Driver: apply one stage request at a falling edge and queue its outcome.
  task automatic drive(input logic v, input logic [PC_W-1:0] pc, input logic [3:0] lvl,
                       input logic ic, input logic ib, input logic bw, input logic bn,
                       input logic db, input logic [IDX_W-1:0] idx,
                       input logic taken, input logic [CW-1:0] cause, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = v; req_pc = pc; cur_level = lvl;
    trg_icount = ic; trg_ibreak = ib; trg_brk_wide = bw;
    trg_brk_narrow = bn; trg_dbreak = db; trg_dbreak_idx = idx;
    if (taken) begin
      hold_cause = cause;
      hold_epc = pc;
    end
    e.taken = taken; e.cause = hold_cause; e.epc = hold_epc; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, '0, 4'd0, 0, 0, 0, 0, 0, '0, 1'b0, '0, tag);
  endtask

  // Monitor: results are due just after the rising edge following the drive.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.tag, " redirect (R10)"}, 64'(redirect_o), 64'(e.taken));
      check({e.tag, " status strobe (R9)"}, 64'(ps_low_we_o), 64'(e.taken));
      check({e.tag, " cause"}, 64'(cause_o), 64'(e.cause));
      check({e.tag, " epc (R8)"}, 64'(epc_o), 64'(e.epc));
      if (e.taken) check({e.tag, " status bits R9"}, 64'(ps_low_o), 64'h16);
      check({e.tag, " vector R10"}, 64'(redirect_pc_o), 64'(VEC));
    end
  end

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_pc = '0; cur_level = '0; trg_icount = 0; trg_ibreak = 0;
    trg_brk_wide = 0; trg_brk_narrow = 0; trg_dbreak = 0; trg_dbreak_idx = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 cause", 64'(cause_o), 0);
    check("R1 epc", 64'(epc_o), 0);
    check("R1 redirect", 64'(redirect_o), 0);
    check("R1 status", 64'({ps_low_we_o, ps_low_o}), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 after release", 64'({cause_o, redirect_o}), 0);

    // R3 single sources
    drive(1, 32'h100, 0, 1, 0, 0, 0, 0, 0, 1, 10'h001, "R3 icount");
    idle("R10 pulse ends");
    drive(1, 32'h104, 2, 0, 1, 0, 0, 0, 0, 1, 10'h002, "R3 ibreak");
    drive(1, 32'h108, 5, 0, 0, 1, 0, 0, 0, 1, 10'h008, "R3 wide break");
    drive(1, 32'h10c, 1, 0, 0, 0, 1, 0, 0, 1, 10'h010, "R3 narrow break");
    drive(1, 32'h110, 0, 0, 0, 0, 0, 1, 0, 1, 10'h004, "R3 dbreak idx0");
    // R4 comparator index field
    drive(1, 32'h114, 0, 0, 0, 0, 0, 1, 1, 1, 10'h104, "R4 dbreak idx1");
    drive(1, 32'h118, 3, 0, 0, 0, 0, 1, 3, 1, 10'h304, "R4 dbreak idx3");
    // Priority
    drive(1, 32'h11c, 0, 1, 1, 1, 1, 1, 2, 1, 10'h001, "R5 all sources");
    drive(1, 32'h120, 0, 0, 1, 1, 0, 0, 0, 1, 10'h002, "R6 ibreak over wide");
    drive(1, 32'h124, 0, 0, 1, 0, 1, 1, 1, 1, 10'h002, "R6 ibreak over narrow");
    drive(1, 32'h128, 0, 0, 0, 1, 0, 1, 1, 1, 10'h008, "R7 wide over dbreak");
    drive(1, 32'h12c, 0, 0, 0, 0, 1, 1, 2, 1, 10'h010, "R7 narrow over dbreak");
    drive(1, 32'h130, 0, 0, 0, 1, 1, 0, 0, 1, 10'h008, "R7 wide over narrow");
    idle("R10 idle");
    // Level masking
    drive(1, 32'h200, 6, 0, 0, 1, 0, 0, 0, 0, '0, "R2 level 6");
    drive(1, 32'h204, 15, 1, 1, 1, 1, 1, 3, 0, '0, "R2 level 15");
    drive(1, 32'h208, 7, 0, 0, 0, 0, 1, 1, 0, '0, "R2 level 7");
    drive(1, 32'h20c, 5, 0, 0, 0, 0, 1, 1, 1, 10'h104, "R2 level 5 taken");
    // No valid / no trigger
    drive(0, 32'h300, 0, 1, 1, 1, 1, 1, 3, 0, '0, "R11 not valid");
    drive(1, 32'h304, 0, 0, 0, 0, 0, 0, 2, 0, '0, "R11 no trigger");
    drive(1, 32'h308, 0, 0, 0, 1, 0, 0, 0, 1, 10'h008, "R8 back to back 1");
    drive(1, 32'h30c, 0, 0, 0, 0, 1, 0, 0, 1, 10'h010, "R8 back to back 2");
    idle("R10 final idle");
    idle("R11 final hold");
    @(posedge clk); #2;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule